// File: doc/BRIEF.md
# External Data-Memory Bus Sequencer

This block runs one external data-memory transfer over the general-purpose I/O ports. A start request carries a 16-bit or 8-bit address, a byte to write, the transfer direction and an 8-bit configuration byte. The block then steps through the bus phases. It places the address bytes on the ports and pulses an address-latch strobe when port 0 carries both address and data. It drives the active-low read or write strobe and captures the returned byte. When the transfer ends it puts the ports back into their post-access state and signals completion.

Phase lengths are counted in ticks of a selectable timing source rather than in clock cycles. The configuration byte fixes the tick count of each standard wait. It can move the low address byte to port 1 so that no latch strobe is needed. It can shorten the read, and it can leave ports 1 and 2 holding the address after the transfer instead of restoring them. The block owns the output latches of ports 0, 1 and 2. All three come out of reset at all-ones.

Configuration byte layout:

| Bits | Meaning |
|------|---------|
| 2:0 | period `p` |
| 3 | tick source: 1 selects `lineTick`, 0 selects `oscTick` |
| 4 | keep ports 1 and 2 (1) or restore them (0) |
| 5 | fast read |
| 6 | split address: low byte on port 1 (1) or shared on port 0 (0) |
| 7 | port mode: high-efficiency (1) or legacy (0) |

Top module: `membus_seq`

## Requirements
- R1: After reset, `p0Out`, `p1Out` and `p2Out` read FF, `p0Drive`, `aleOut` and `done` are 0, `rdN` and `wrN` are 1, and `rdData` is 00.
- R2: `startReq` is taken only while the block is idle. A request raised during a transfer changes neither the running transfer nor the outputs afterwards, and it yields no second `done`.
- R3: With config bit 6 clear, port 0 drives the low address byte while `aleOut` is high for one standard wait. It stays there during a further standard wait with `aleOut` low. Only then does port 0 switch to the data phase.
- R4: With config bit 6 set, the low address byte goes out on `p1Out`, port 0 is left alone during the address phase, and `aleOut` never rises.
- R5: A 16-bit request (`wideAddr`=1) places the high address byte on `p2Out` during the strobe phase. An 8-bit request leaves `p2Out` at its previous value.
- R6: A write holds `wrN` low for one standard wait while port 0 drives `wrByte` (`p0Drive`=1). `rdN` stays high throughout.
- R7: A read without fast mode holds `rdN` low for one standard wait with port 0 released (`p0Drive`=0). It then waits one standard wait before `done`. `rdData` takes the `p0In` value present in the last cycle of the low strobe and keeps it while the block is idle.
- R8: With config bit 5 set, a read holds `rdN` low for `p`+1 ticks and skips the recovery wait, so `done` follows the rising `rdN` directly.
- R9: A standard wait lasts 2·(`p`+1) ticks, where `p` is config bits 2:0. Ticks come from `lineTick` when config bit 3 is set, else from `oscTick`. Without ticks from the selected source the transfer does not advance.
- R10: With config bit 4 clear, `p1Out` and `p2Out` return to their pre-transfer values at the end. With it set they keep the transfer values.
- R11: At the end of a transfer, port 0 is released and, in legacy mode (config bit 7 clear), set to FF. In high-efficiency mode it keeps the last byte driven onto it.
- R12: `done` is high for exactly one cycle per accepted request. The final port values are already in place in that cycle.
- R13: `aleOut` and the two strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous reset, active low |
| oscTick | input | 1 | oscillator tick, one-cycle pulse per tick |
| lineTick | input | 1 | delay-line tick, one-cycle pulse per tick |
| startReq | input | 1 | request a transfer (taken when idle) |
| isWrite | input | 1 | 1 = write, 0 = read |
| wideAddr | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| addr | input | 16 | transfer address |
| wrByte | input | 8 | byte to write |
| cfg | input | 8 | configuration byte, sampled at start |
| p0In | input | 8 | sampled port 0 pins |
| p0Out | output | 8 | port 0 output latch |
| p0Drive | output | 1 | port 0 actively driven by the bus |
| p1Out | output | 8 | port 1 output latch |
| p2Out | output | 8 | port 2 output latch |
| aleOut | output | 1 | address latch strobe, active high |
| rdN | output | 1 | read strobe, active low |
| wrN | output | 1 | write strobe, active low |
| done | output | 1 | transfer complete pulse |
| rdData | output | 8 | byte returned by the last read |

## Verification
On every cycle the assertions check the following:
- strobe exclusivity;
- port 0 drive direction under each strobe;
- a stable address at the falling latch strobe;
- a stable write byte under the write strobe;
- a single-cycle `done`;
- a configuration that stays frozen while busy;
- a wait counter that holds when no tick arrives.

Only the bench scenarios can show the remaining behaviour:
- the tick-exact phase lengths for each period, tick source and fast-read setting;
- which port carries which address byte;
- the captured read byte;
- the restore-or-keep result on ports 0, 1 and 2;
- that a request raised mid-transfer has no effect.

// File: rtl/membus_pkg.sv
package membus_pkg;

  localparam int PERIOD_W = 3;
  localparam int CNT_W    = PERIOD_W + 2;

  // Configuration byte; field order fixes the bit positions (bit 7 first).
  typedef struct packed {
    logic                hiEff;
    logic                demux;
    logic                fastRd;
    logic                sustain;
    logic                lineSrc;
    logic [PERIOD_W-1:0] period;
  } cfg_t;

  // Strobes from the control FSM to the port datapath.
  typedef struct packed {
    logic latchReq;
    logic putAddr;
    logic putWrData;
    logic floatP0;
    logic grabRead;
    logic finish;
  } dpCtl_t;

  typedef enum logic [3:0] {
    S_IDLE, S_SYNC, S_ALE_HI, S_ALE_LO,
    S_WR, S_WR_HOLD, S_RD, S_RD_REC, S_DONE
  } seqState_t;

endpackage

// File: rtl/membus_wait.sv
module membus_wait #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscTick,
  input  logic             lineTick,
  input  logic             useLine,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  output logic             expire
);

  logic             tickSel;
  logic [CNT_W-1:0] cnt;

  assign tickSel = useLine ? lineTick : oscTick;
  assign expire  = tickSel && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= loadVal;
    end else if (tickSel && cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R9: without a tick from the chosen source the wait does not move
  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!tickSel && !load) |=> $stable(cnt));

endmodule

// File: rtl/membus_ctrl.sv
module membus_ctrl
  import membus_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                isWrite,
  input  logic [PERIOD_W-1:0] periodIn,
  input  logic                lineIn,
  input  logic                demuxIn,
  input  logic                fastIn,
  input  logic                expire,
  output dpCtl_t              dpCtl,
  output logic                loadCnt,
  output logic [CNT_W-1:0]    cntVal,
  output logic                useLine,
  output logic                aleOut,
  output logic                rdN,
  output logic                wrN,
  output logic                done
);

  seqState_t           state, nxt;
  logic                wrQ, lineQ, demuxQ, fastQ;
  logic [PERIOD_W-1:0] periodQ;
  logic [CNT_W-1:0]    lenBase, lenStd, lenFast;
  logic                goData;

  assign lenBase = {2'b00, periodQ} + CNT_W'(1);
  assign lenStd  = lenBase << 1;
  assign lenFast = lenBase;
  assign useLine = lineQ;

  assign goData = expire && ((state == S_SYNC && demuxQ) || state == S_ALE_LO);

  always_comb begin
    nxt     = state;
    dpCtl   = '0;
    loadCnt = 1'b0;
    cntVal  = '0;
    unique case (state)
      S_IDLE: if (startReq) begin
        nxt            = S_SYNC;
        dpCtl.latchReq = 1'b1;
        loadCnt        = 1'b1;
        cntVal         = CNT_W'(1);
      end
      S_SYNC: if (expire) begin
        dpCtl.putAddr = 1'b1;
        if (!demuxQ) begin
          nxt     = S_ALE_HI;
          loadCnt = 1'b1;
          cntVal  = lenStd;
        end
      end
      S_ALE_HI: if (expire) begin
        nxt     = S_ALE_LO;
        loadCnt = 1'b1;
        cntVal  = lenStd;
      end
      S_ALE_LO: ;
      S_WR: if (expire) begin
        nxt     = S_WR_HOLD;
        loadCnt = 1'b1;
        cntVal  = lenStd;
      end
      S_WR_HOLD: if (expire) begin
        nxt          = S_DONE;
        dpCtl.finish = 1'b1;
      end
      S_RD: if (expire) begin
        dpCtl.grabRead = 1'b1;
        if (fastQ) begin
          nxt          = S_DONE;
          dpCtl.finish = 1'b1;
        end else begin
          nxt     = S_RD_REC;
          loadCnt = 1'b1;
          cntVal  = lenStd;
        end
      end
      S_RD_REC: if (expire) begin
        nxt          = S_DONE;
        dpCtl.finish = 1'b1;
      end
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase

    // entry into the strobe phase, shared by both address layouts
    if (goData) begin
      loadCnt = 1'b1;
      if (wrQ) begin
        nxt             = S_WR;
        dpCtl.putWrData = 1'b1;
        cntVal          = lenStd;
      end else begin
        nxt           = S_RD;
        dpCtl.floatP0 = 1'b1;
        cntVal        = fastQ ? lenFast : lenStd;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      wrQ     <= 1'b0;
      lineQ   <= 1'b0;
      demuxQ  <= 1'b0;
      fastQ   <= 1'b0;
      periodQ <= '0;
    end else begin
      state <= nxt;
      if (dpCtl.latchReq) begin
        wrQ     <= isWrite;
        lineQ   <= lineIn;
        demuxQ  <= demuxIn;
        fastQ   <= fastIn;
        periodQ <= periodIn;
      end
    end
  end

  assign aleOut = (state == S_ALE_HI);
  assign rdN    = (state != S_RD);
  assign wrN    = (state != S_WR);
  assign done   = (state == S_DONE);

  // R2: a running transfer keeps the settings it started with
  a_r2_cfg_frozen_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |=> ($stable(periodQ) && $stable(fastQ) && $stable(demuxQ)
                           && $stable(lineQ) && $stable(wrQ)));

  // R12: completion is a one-cycle pulse
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/membus_dp.sv
module membus_dp
  import membus_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              isWide,
  input  logic              demuxIn,
  input  logic              sustainIn,
  input  logic              hiEffIn,
  input  logic [DATA_W-1:0] p0In,
  output logic [DATA_W-1:0] p0Out,
  output logic              p0Drive,
  output logic [DATA_W-1:0] p1Out,
  output logic [DATA_W-1:0] p2Out,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrQ, sav1, sav2;
  logic              wideQ, dxQ, suQ, heQ;
  logic [DATA_W-1:0] addrLo, addrHi;

  assign addrLo = addrQ[DATA_W-1:0];
  assign addrHi = addrQ[ADDR_W-1:DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrQ     <= '0;
      sav1    <= '1;
      sav2    <= '1;
      wideQ   <= 1'b0;
      dxQ     <= 1'b0;
      suQ     <= 1'b0;
      heQ     <= 1'b0;
      p0Out   <= '1;
      p0Drive <= 1'b0;
      p1Out   <= '1;
      p2Out   <= '1;
      rdData  <= '0;
    end else begin
      if (ctl.latchReq) begin
        addrQ <= addr;
        wrQ   <= wrByte;
        wideQ <= isWide;
        dxQ   <= demuxIn;
        suQ   <= sustainIn;
        heQ   <= hiEffIn;
        sav1  <= p1Out;
        sav2  <= p2Out;
      end
      if (ctl.putAddr) begin
        if (!dxQ) begin
          p0Out   <= addrLo;
          p0Drive <= 1'b1;
        end else begin
          p1Out <= addrLo;
        end
        if (wideQ) p2Out <= addrHi;
      end
      if (ctl.putWrData) begin
        p0Out   <= wrQ;
        p0Drive <= 1'b1;
      end
      if (ctl.floatP0) p0Drive <= 1'b0;
      if (ctl.grabRead) rdData <= p0In;
      if (ctl.finish) begin
        p0Drive <= 1'b0;
        if (!heQ) p0Out <= '1;
        if (!suQ) begin
          p1Out <= sav1;
          p2Out <= sav2;
        end
      end
    end
  end

  // R7: the returned byte changes only when a read completes
  a_r7_rddata_held: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.grabRead |=> $stable(rdData));

endmodule

// File: rtl/membus_seq.sv
module membus_seq
  import membus_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscTick,
  input  logic              lineTick,
  input  logic              startReq,
  input  logic              isWrite,
  input  logic              wideAddr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrByte,
  input  logic [7:0]        cfg,
  input  logic [DATA_W-1:0] p0In,
  output logic [DATA_W-1:0] p0Out,
  output logic              p0Drive,
  output logic [DATA_W-1:0] p1Out,
  output logic [DATA_W-1:0] p2Out,
  output logic              aleOut,
  output logic              rdN,
  output logic              wrN,
  output logic              done,
  output logic [DATA_W-1:0] rdData
);

  cfg_t             cfgS;
  dpCtl_t           dpCtl;
  logic             loadCnt, useLine, expire;
  logic [CNT_W-1:0] cntVal;

  assign cfgS = cfg_t'(cfg);

  membus_wait #(.CNT_W(CNT_W)) wait_i (
    .clk      (clk),
    .rstN     (rstN),
    .oscTick  (oscTick),
    .lineTick (lineTick),
    .useLine  (useLine),
    .load     (loadCnt),
    .loadVal  (cntVal),
    .expire   (expire)
  );

  membus_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .isWrite  (isWrite),
    .periodIn (cfgS.period),
    .lineIn   (cfgS.lineSrc),
    .demuxIn  (cfgS.demux),
    .fastIn   (cfgS.fastRd),
    .expire   (expire),
    .dpCtl    (dpCtl),
    .loadCnt  (loadCnt),
    .cntVal   (cntVal),
    .useLine  (useLine),
    .aleOut   (aleOut),
    .rdN      (rdN),
    .wrN      (wrN),
    .done     (done)
  );

  membus_dp #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (dpCtl),
    .addr      (addr),
    .wrByte    (wrByte),
    .isWide    (wideAddr),
    .demuxIn   (cfgS.demux),
    .sustainIn (cfgS.sustain),
    .hiEffIn   (cfgS.hiEff),
    .p0In      (p0In),
    .p0Out     (p0Out),
    .p0Drive   (p0Drive),
    .p1Out     (p1Out),
    .p2Out     (p2Out),
    .rdData    (rdData)
  );

  // R3: the address is still on port 0 when the latch strobe falls
  a_r3_addr_at_ale_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(aleOut) |-> ($stable(p0Out) && p0Drive));

  // R6: the write strobe only runs with port 0 driven and steady
  a_r6_wr_drives_p0: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> p0Drive);
  a_r6_wr_data_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && $past(!wrN)) |-> $stable(p0Out));

  // R7: port 0 is released while the read strobe is low
  a_r7_rd_floats_p0: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !p0Drive);

  // R13: strobes are mutually exclusive
  a_r13_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $countones({aleOut, !rdN, !wrN}) <= 1);

  // R12: ports are final when completion is signalled
  a_r12_ports_settled: assert property (@(posedge clk) disable iff (!rstN)
    done |=> ($stable(p1Out) && $stable(p2Out) && $stable(p0Out)));

endmodule

// File: tb/membus_seq_tb.sv
module membus_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        oscTick = 1'b1;
  logic        lineTick = 1'b0;
  logic        startReq = 1'b0;
  logic        isWrite = 1'b0;
  logic        wideAddr = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wrByte = '0;
  logic [7:0]  cfg = '0;
  logic [7:0]  p0In = '0;
  logic [7:0]  p0Out, p1Out, p2Out, rdData;
  logic        p0Drive, aleOut, rdN, wrN, done;

  int nChecks = 0;
  int nFail = 0;

  logic lineGen = 1'b0;
  int   divCnt = 0;

  // per-transfer observations
  int   mAleHi, mAleGap, mRdLow, mWrLow, mRdToDone, mDone;
  logic [7:0] mP0Ale, mP0Wr, mP1Str, mP2Str;
  bit   mDrvWrOk, mDrvRd, mTailAct, mStallMoved;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    divCnt   <= (divCnt == 2) ? 0 : divCnt + 1;
    lineTick <= lineGen && (divCnt == 2);
  end

  membus_seq dut_i (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .lineTick(lineTick),
    .startReq(startReq), .isWrite(isWrite), .wideAddr(wideAddr),
    .addr(addr), .wrByte(wrByte), .cfg(cfg), .p0In(p0In),
    .p0Out(p0Out), .p0Drive(p0Drive), .p1Out(p1Out), .p2Out(p2Out),
    .aleOut(aleOut), .rdN(rdN), .wrN(wrN), .done(done), .rdData(rdData)
  );

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  task automatic runAccess(input bit wr, input bit wide, input logic [15:0] a,
                           input logic [7:0] d, input logic [7:0] c,
                           input logic [7:0] rv, input bit poke, input int stall);
    bit seenAle, seenStr, seenRd, fin;
    mAleHi = 0; mAleGap = 0; mRdLow = 0; mWrLow = 0; mRdToDone = 0; mDone = 0;
    mP0Ale = 0; mP0Wr = 0; mP1Str = 0; mP2Str = 0;
    mDrvWrOk = 1; mDrvRd = 0; mTailAct = 0; mStallMoved = 0;
    seenAle = 0; seenStr = 0; seenRd = 0; fin = 0;
    @(negedge clk);
    isWrite = wr; wideAddr = wide; addr = a; wrByte = d; cfg = c; startReq = 1'b1;
    lineGen = 1'b0;
    @(negedge clk);
    startReq = 1'b0;
    if (stall > 0) begin
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        if (done || aleOut || !rdN || !wrN) mStallMoved = 1;
      end
      lineGen = 1'b1;
    end
    for (int i = 0; i < 3000 && !fin; i++) begin
      @(negedge clk);
      if (poke && i == 2) begin
        startReq = 1'b1; addr = 16'hFFFF; wrByte = 8'h00; isWrite = !wr;
      end
      if (poke && i == 3) startReq = 1'b0;
      p0In = (!rdN) ? rv : 8'h00;
      if (aleOut) begin mAleHi++; mP0Ale = p0Out; seenAle = 1; end
      if (seenAle && !aleOut && rdN && wrN && !seenStr && !done) mAleGap++;
      if (!rdN) begin
        mRdLow++; seenStr = 1; seenRd = 1;
        if (p0Drive) mDrvRd = 1;
        mP1Str = p1Out; mP2Str = p2Out;
      end
      if (!wrN) begin
        mWrLow++; seenStr = 1; mP0Wr = p0Out;
        if (!p0Drive) mDrvWrOk = 0;
        mP1Str = p1Out; mP2Str = p2Out;
      end
      if (seenRd && rdN && !done) mRdToDone++;
      if (done) begin mDone++; fin = 1; end
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done) mDone++;
      if (aleOut || !rdN || !wrN) mTailAct = 1;
    end
    lineGen = 1'b0;
  endtask

  task automatic t_reset();
    chkEq("R1 p0Out", p0Out, 8'hFF);
    chkEq("R1 p1Out", p1Out, 8'hFF);
    chkEq("R1 p2Out", p2Out, 8'hFF);
    chkEq("R1 strobes {ale,rdN,wrN,done,p0Drive}",
          {aleOut, rdN, wrN, done, p0Drive}, 5'b01100);
    chkEq("R1 rdData", rdData, 8'h00);
  endtask

  // legacy layout, 16-bit write, period 1 -> standard wait 4 ticks
  task automatic t_legacyWrite();
    runAccess(1, 1, 16'h12A5, 8'h3C, 8'h01, 8'h00, 0, 0);
    chkEq("R3 R9 ale high ticks", mAleHi, 4);
    chkEq("R3 ale low gap", mAleGap, 4);
    chkEq("R3 p0 address during ale", mP0Ale, 8'hA5);
    chkEq("R6 wrN low ticks", mWrLow, 4);
    chkEq("R6 p0 write byte", mP0Wr, 8'h3C);
    chkEq("R6 p0 driven under wrN", mDrvWrOk, 1);
    chkEq("R6 rdN stays high", mRdLow, 0);
    chkEq("R5 p2 high address", mP2Str, 8'h12);
    chkEq("R3 p1 untouched", mP1Str, 8'hFF);
    chkEq("R12 one done", mDone, 1);
    chkEq("R11 legacy p0 FF", p0Out, 8'hFF);
    chkEq("R11 p0 released", p0Drive, 0);
    chkEq("R10 p2 restored", p2Out, 8'hFF);
  endtask

  // legacy layout, 8-bit read, period 0 -> standard wait 2 ticks
  task automatic t_legacyRead();
    runAccess(0, 0, 16'h0077, 8'h00, 8'h00, 8'hC3, 0, 0);
    chkEq("R3 ale high ticks", mAleHi, 2);
    chkEq("R3 p0 address", mP0Ale, 8'h77);
    chkEq("R7 rdN low ticks", mRdLow, 2);
    chkEq("R7 p0 released under rdN", mDrvRd, 0);
    chkEq("R7 read byte", rdData, 8'hC3);
    chkEq("R7 recovery wait", mRdToDone, 2);
    chkEq("R5 narrow p2 unchanged", mP2Str, 8'hFF);
    chkEq("R13 wrN stays high", mWrLow, 0);
  endtask

  // split address, fast read, keep ports, period 2
  task automatic t_fastRead();
    runAccess(0, 1, 16'hBE42, 8'h00, 8'h72, 8'h5A, 0, 0);
    chkEq("R8 rdN low ticks", mRdLow, 3);
    chkEq("R8 no recovery", mRdToDone, 0);
    chkEq("R4 no ale", mAleHi, 0);
    chkEq("R4 p1 low address", mP1Str, 8'h42);
    chkEq("R5 p2 high address", mP2Str, 8'hBE);
    chkEq("R10 sustain p1", p1Out, 8'h42);
    chkEq("R10 sustain p2", p2Out, 8'hBE);
    chkEq("R8 read byte", rdData, 8'h5A);
  endtask

  task automatic t_readHold();
    @(negedge clk);
    p0In = 8'h11;
    repeat (5) @(negedge clk);
    chkEq("R7 read byte held in idle", rdData, 8'h5A);
  endtask

  // high-efficiency port mode, split address, restore, busy request ignored
  task automatic t_heWriteBusyPoke();
    runAccess(1, 0, 16'h0009, 8'h81, 8'hC0, 8'h00, 1, 0);
    chkEq("R6 wrN low ticks", mWrLow, 2);
    chkEq("R4 p1 low address", mP1Str, 8'h09);
    chkEq("R5 narrow p2 unchanged", mP2Str, 8'hBE);
    chkEq("R2 write byte unaffected", mP0Wr, 8'h81);
    chkEq("R2 one done only", mDone, 1);
    chkEq("R2 no second transfer", mTailAct, 0);
    chkEq("R10 p1 restored", p1Out, 8'h42);
    chkEq("R10 p2 restored", p2Out, 8'hBE);
    chkEq("R11 high-eff p0 keeps byte", p0Out, 8'h81);
  endtask

  // line tick source: nothing moves until it ticks, then 3 cycles per tick
  task automatic t_lineSource();
    runAccess(1, 1, 16'h3456, 8'hE7, 8'h48, 8'h00, 0, 30);
    chkEq("R9 stalled without line tick", mStallMoved, 0);
    chkEq("R9 wrN low cycles at 1 tick/3 cycles", mWrLow, 6);
    chkEq("R5 p2 high address", mP2Str, 8'h34);
    chkEq("R10 p1 restored", p1Out, 8'h42);
    chkEq("R11 legacy p0 FF", p0Out, 8'hFF);
  endtask

  // largest period: fast and standard read lengths
  task automatic t_maxPeriod();
    runAccess(0, 0, 16'h0001, 8'h00, 8'h67, 8'h99, 0, 0);
    chkEq("R8 fast rdN at period 7", mRdLow, 8);
    runAccess(0, 0, 16'h0002, 8'h00, 8'h47, 8'h66, 0, 0);
    chkEq("R9 standard rdN at period 7", mRdLow, 16);
    chkEq("R7 read byte", rdData, 8'h66);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R12 watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_legacyWrite();
    t_legacyRead();
    t_fastRead();
    t_readHold();
    t_heWriteBusyPoke();
    t_lineSource();
    t_maxPeriod();
    summary();
    $finish;
  end

endmodule